// File: doc/BRIEF.md
# Buffered UART Transmitter with Clear-to-Send Gating

This block serialises words onto an asynchronous serial line. A single holding register sits in front of a frame shifter. A word written into the holding register moves into the shifter as soon as the shifter is free and transmission is permitted. A frame is a low start bit, then 8 or 9 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The line rests high between frames.

The bit period is set by a divider value and is measured in system clocks. An optional active-low clear-to-send input, passed through a two-stage synchroniser, can hold back the next frame. It is consulted only when a frame would start, so a frame that has begun always runs to its end. Two status outputs report an empty holding register and an idle shifter. A sticky interrupt request fires on one of two events, chosen by a select input. A sticky overrun flag records a write that arrived while the holding register was still occupied.

Top module: `uart_cts_tx`

## Requirements
- R1: One bit lasts exactly 16 × (div_val + 1) clock cycles, so a frame of L bits keeps shift_empty low for L × 16 × (div_val + 1) cycles.
- R2: A frame starts with a 0 start bit, sends the data bits least significant bit first, and ends with stop bits at 1. txd is 1 whenever shift_empty is 1.
- R3: With fmt_9bit = 1 the frame carries 9 data bits (bit 8 last). With stop_two = 1 it ends with two stop bits.
- R4: With par_en = 1 a parity bit follows the last data bit. It is the XOR of all sent data bits, inverted when par_odd = 1.
- R5: When the shifter is idle, a buffered word is loaded one clock after its write is accepted. In that cycle buf_empty becomes 1 and shift_empty becomes 0. shift_empty returns to 1 after the last stop bit only when no word is waiting.
- R6: If a word is waiting at the end of a stop bit and sending is permitted, its start bit begins in the very next clock. There is no idle gap between frames.
- R7: With cts_en = 1, a frame starts only while the synchronised cts_n is 0. cts_n going high during a frame does not cut that frame short. A held word starts after cts_n returns low.
- R8: While tx_en is 0 no frame starts, and a written word stays in the holding register.
- R9: With irq_sel = 0, irq sets when a word moves from the holding register into the shifter. With irq_sel = 1, irq sets when the last stop bit ends and no word follows. irq stays 1 until irq_clr is pulsed.
- R10: A write while buf_empty is 0 is discarded and sets overrun. overrun stays 1 until ovr_clr is pulsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Permits new frames to start |
| div_val | input | DIV_W | Bit period divider n, period = 16(n+1) clocks |
| fmt_9bit | input | 1 | 1 = nine data bits, 0 = eight |
| par_en | input | 1 | Adds a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| stop_two | input | 1 | 1 = two stop bits, 0 = one |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| irq_sel | input | 1 | 0 = request on buffer empty, 1 = on transmission complete |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send |
| irq_clr | input | 1 | Clears the interrupt request |
| ovr_clr | input | 1 | Clears the overrun flag |
| txd | output | 1 | Serial line output, idle high |
| buf_empty | output | 1 | Holding register free |
| shift_empty | output | 1 | Shifter idle, no frame on the line |
| irq | output | 1 | Sticky interrupt request |
| overrun | output | 1 | Sticky write-while-full flag |

## Verification
The checker watches, on every cycle, the relations that hold between neighbouring cycles. These are: the idle line is high; a load always leaves the holding register free; no start occurs while sending is disabled or while the synchronised clear-to-send is high; the interrupt and overrun flags persist; and the buffer-empty event raises the request. Only the bench scenarios can show the content and timing of whole frames: the exact bit period, the parity value, nine-bit and two-stop framing, zero-gap back-to-back frames, a frame completing after clear-to-send drops mid-frame, and the discarded overrun word never reaching the line.

// File: rtl/uart_tx_pkg.sv
// Shared constants, the frame format type and frame-building helpers for
// the buffered UART transmitter. Assumes at most 9 data bits, one parity
// bit and two stop bits per frame.
package uart_tx_pkg;

    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned OVS_W      = $clog2(OVERSAMPLE);
    localparam int unsigned MAX_DATA   = 9;
    localparam int unsigned FRAME_W    = 1 + MAX_DATA + 1 + 2;
    localparam int unsigned LEN_W      = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
        logic stop2;
    } fmt_t;

    // Builds the full frame, bit 0 first on the line; unused upper bits are 1.
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [MAX_DATA-1:0] d,
        input fmt_t                f
    );
        logic [FRAME_W-1:0] fr;
        logic               p;
        int                 dl;
        dl    = f.nine ? 9 : 8;
        fr    = '1;
        fr[0] = 1'b0;
        p     = f.par_odd;
        for (int i = 0; i < int'(MAX_DATA); i++) begin
            if (i < dl) begin
                fr[1 + i] = d[i];
                p         = p ^ d[i];
            end
        end
        if (f.par_en) begin
            fr[1 + dl] = p;
        end
        return fr;
    endfunction

    // Total number of bits in a frame of the given format.
    function automatic logic [LEN_W-1:0] frame_len(input fmt_t f);
        return LEN_W'(10) + LEN_W'(f.nine) + LEN_W'(f.par_en) + LEN_W'(f.stop2);
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
// Bit-period timer. Counts 16*(div+1) clocks per bit while run is high and
// pulses tick on the last clock of each bit. restart zeroes the count so
// that a new frame begins on a fresh bit boundary. Assumes div is held
// steady during a frame.
module uart_tx_baud
    import uart_tx_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam int unsigned CNT_W = DIV_W + OVS_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count value of a bit: 16*(div+1)-1.
    assign last = (CNT_W'(div) * CNT_W'(OVERSAMPLE)) + CNT_W'(OVERSAMPLE - 1);
    assign tick = run && (cnt == last);

    // Advances the in-bit counter and wraps it at the end of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_sync.sv
// Multi-stage synchroniser for an asynchronous level input. Resets to the
// idle level so that nothing is seen as asserted straight out of reset.
module uart_tx_sync #(
    parameter int unsigned STAGES   = 2,
    parameter logic        IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shifts the input through the flop chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{IDLE_LVL}};
                else        chain <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{IDLE_LVL}};
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/uart_tx_shifter.sv
// Frame shifter. On start it captures a full frame built from the data
// word and format, then moves one bit per tick onto the line. done pulses
// on the tick that ends the last stop bit. start wins over that final tick,
// which gives back-to-back frames with no idle clock between them.
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [MAX_DATA-1:0] data,
    input  fmt_t                fmt,
    input  logic                tick,
    output logic                busy,
    output logic                done,
    output logic                line
);

    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   left;

    assign done = tick && (left == '0);
    assign line = busy ? frame[0] : 1'b1;

    // Loads a new frame or shifts out one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '1;
            left  <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            frame <= build_frame(data, fmt);
            left  <= frame_len(fmt) - 1'b1;
            busy  <= 1'b1;
        end else if (tick) begin
            if (left == '0) begin
                busy <= 1'b0;
            end else begin
                frame <= {1'b1, frame[FRAME_W-1:1]};
                left  <= left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_cts_tx.sv
// Buffered UART transmitter top. Holds one word in front of the frame
// shifter, gates frame starts on enable and synchronised clear-to-send,
// and keeps the sticky interrupt and overrun flags. Assumes format and
// divider inputs are changed only while the transmitter is idle.
module uart_cts_tx
    import uart_tx_pkg::*;
#(
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned CTS_STAGE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic [DIV_W-1:0]    div_val,
    input  logic                fmt_9bit,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                stop_two,
    input  logic                cts_en,
    input  logic                cts_n,
    input  logic                irq_sel,
    input  logic                wr_valid,
    input  logic [MAX_DATA-1:0] wr_data,
    input  logic                irq_clr,
    input  logic                ovr_clr,
    output logic                txd,
    output logic                buf_empty,
    output logic                shift_empty,
    output logic                irq,
    output logic                overrun
);

    logic [MAX_DATA-1:0] hold_q;
    logic                hold_full;
    logic                cts_s;
    logic                cts_ok;
    logic                busy;
    logic                done;
    logic                tick;
    logic                start;
    logic                irq_evt;
    fmt_t                fmt;

    assign fmt = '{nine: fmt_9bit, par_en: par_en, par_odd: par_odd, stop2: stop_two};

    uart_tx_sync #(.STAGES(CTS_STAGE), .IDLE_LVL(1'b1)) u_cts_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_n),
        .sync_out (cts_s)
    );

    assign cts_ok = !cts_en || !cts_s;
    assign start  = hold_full && tx_en && cts_ok && (!busy || done);

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (busy),
        .div     (div_val),
        .tick    (tick)
    );

    uart_tx_shifter u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .data  (hold_q),
        .fmt   (fmt),
        .tick  (tick),
        .busy  (busy),
        .done  (done),
        .line  (txd)
    );

    // Holding register: accepts a write when free, releases it on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (start) begin
            hold_full <= 1'b0;
        end else if (wr_valid && !hold_full) begin
            hold_q    <= wr_data;
            hold_full <= 1'b1;
        end
    end

    // Sticky overrun flag for writes that find the holding register full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (wr_valid && hold_full) begin
            overrun <= 1'b1;
        end else if (ovr_clr) begin
            overrun <= 1'b0;
        end
    end

    assign irq_evt = irq_sel ? (done && !start) : start;

    // Sticky interrupt request; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (irq_evt) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    assign buf_empty   = !hold_full;
    assign shift_empty = !busy;

endmodule

// File: rtl/uart_cts_tx_chk.sv
// Cycle-level property checker for the buffered UART transmitter, attached
// to every instance of the top module by the bind below.
module uart_cts_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic cts_en,
    input logic cts_n,
    input logic irq_sel,
    input logic irq_clr,
    input logic ovr_clr,
    input logic txd,
    input logic buf_empty,
    input logic shift_empty,
    input logic irq,
    input logic overrun
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd); // R2

    AST_LOAD_FREES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> buf_empty); // R5

    AST_CTS_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_en && shift_empty && $past(cts_n, 2)) |=> shift_empty); // R7

    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && shift_empty) |=> shift_empty); // R8

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R9

    AST_IRQ_ON_BUF_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(buf_empty) && !$past(irq_sel)) |-> irq); // R9

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun); // R10

endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .cts_en      (cts_en),
    .cts_n       (cts_n),
    .irq_sel     (irq_sel),
    .irq_clr     (irq_clr),
    .ovr_clr     (ovr_clr),
    .txd         (txd),
    .buf_empty   (buf_empty),
    .shift_empty (shift_empty),
    .irq         (irq),
    .overrun     (overrun)
);

// File: tb/sim_uart_cts_tx.sv
// Scoreboard bench: the driver queues expected frames, the monitor decodes
// the serial line and compares each frame against the queue head.
module sim_uart_cts_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1;
    logic [7:0] div_val = 8'd0;
    logic       fmt_9bit = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop_two = 1'b0;
    logic       cts_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       irq_sel = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic       irq_clr = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       txd, buf_empty, shift_empty, irq, overrun;

    always #5 clk = ~clk;

    uart_cts_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .div_val(div_val),
        .fmt_9bit(fmt_9bit), .par_en(par_en), .par_odd(par_odd),
        .stop_two(stop_two), .cts_en(cts_en), .cts_n(cts_n),
        .irq_sel(irq_sel), .wr_valid(wr_valid), .wr_data(wr_data),
        .irq_clr(irq_clr), .ovr_clr(ovr_clr), .txd(txd),
        .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq),
        .overrun(overrun)
    );

    typedef struct {
        logic [8:0] d;
        int         gap;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   rx_frames = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int bit_p();
        return 16 * (int'(div_val) + 1);
    endfunction

    function automatic int flen();
        return 10 + int'(fmt_9bit) + int'(par_en) + int'(stop_two);
    endfunction

    // Expected line level of bit k of a frame carrying d.
    function automatic logic exp_bit(input int k, input logic [8:0] d);
        int   dl;
        logic p;
        dl = fmt_9bit ? 9 : 8;
        if (k == 0) return 1'b0;
        if (k <= dl) return d[k-1];
        if (par_en && k == dl + 1) begin
            p = par_odd;
            for (int i = 0; i < dl; i++) p = p ^ d[i];
            return p;
        end
        return 1'b1;
    endfunction

    // Monitor: decodes frames at bit centres and checks them against the queue.
    initial begin
        int   last_t0;
        int   t0;
        int   len;
        int   per;
        exp_t e;
        logic [12:0] got;
        logic [12:0] want;
        string tag;
        last_t0 = 0;
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin
                t0  = cyc;
                len = flen();
                per = bit_p();
                got = '1;
                want = '1;
                repeat (per / 2) @(negedge clk);
                got[0] = txd;
                for (int k = 1; k < len; k++) begin
                    repeat (per) @(negedge clk);
                    got[k] = txd;
                end
                rx_frames++;
                if (q.size() == 0) begin
                    chk(1'b0, "R10 unexpected frame on line", int'(got), 0);
                end else begin
                    e = q.pop_front();
                    for (int k = 0; k < len; k++) want[k] = exp_bit(k, e.d);
                    if (fmt_9bit || stop_two) tag = "R3 frame bits";
                    else if (par_en)          tag = "R4 frame bits";
                    else                      tag = "R2 frame bits";
                    chk(got == want, tag, int'(got), int'(want));
                    if (e.gap != 0)
                        chk(t0 - last_t0 == e.gap, "R6 start-to-start gap", t0 - last_t0, e.gap);
                end
                last_t0 = t0;
            end
        end
    end

    task automatic push(input logic [8:0] d, input int gap);
        exp_t e;
        e.d = d;
        e.gap = gap;
        q.push_back(e);
    endtask

    task automatic wr(input logic [8:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(shift_empty && buf_empty && q.size() == 0)) @(negedge clk);
        repeat (bit_p()) @(negedge clk);
    endtask

    // Watchdog: an expired run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Driver: stimulus and directed checks.
    initial begin
        int cnt;
        int f0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R2 idle line after reset", txd, 1);
        chk(buf_empty == 1'b1, "R5 buffer empty after reset", buf_empty, 1);
        chk(shift_empty == 1'b1, "R5 shifter empty after reset", shift_empty, 1);
        chk(irq == 1'b0 && overrun == 1'b0, "R9 flags clear after reset", {irq, overrun}, 0);

        // R1/R5: single 8N1 frame, divider 2, exact duration.
        div_val = 8'd2;
        push(9'h0A5, 0);
        wr(9'h0A5);
        @(negedge clk);
        chk(buf_empty == 1'b1, "R5 buffer freed on load", buf_empty, 1);
        chk(shift_empty == 1'b0, "R5 shifter busy on load", shift_empty, 0);
        cnt = 0;
        while (!shift_empty) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == flen() * bit_p(), "R1 frame duration", cnt, flen() * bit_p());
        wait_idle();

        // R4: even then odd parity.
        div_val = 8'd0;
        par_en = 1'b1;
        push(9'h05A, 0); wr(9'h05A); wait_idle();
        par_odd = 1'b1;
        push(9'h001, 0); wr(9'h001); wait_idle();
        push(9'h0FF, 0); wr(9'h0FF); wait_idle();

        // R3: nine data bits, two stops, with and without parity.
        fmt_9bit = 1'b1; stop_two = 1'b1;
        push(9'h1A5, 0); wr(9'h1A5); wait_idle();
        par_en = 1'b0;
        push(9'h13C, 0); wr(9'h13C); wait_idle();
        fmt_9bit = 1'b0; stop_two = 1'b0; par_odd = 1'b0;

        // R6/R10: back-to-back frames plus a discarded overrun write.
        push(9'h033, 0);
        push(9'h0C6, flen() * bit_p());
        wr(9'h033);
        @(negedge clk);
        wr(9'h0C6);
        wr(9'h1FF);
        chk(overrun == 1'b1, "R10 overrun set by write to full buffer", overrun, 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk(overrun == 1'b0, "R10 overrun cleared", overrun, 0);
        wait_idle();

        // R9: request on buffer empty, sticky, then cleared.
        pulse_irq_clr();
        irq_sel = 1'b0;
        push(9'h011, 0);
        wr(9'h011);
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq on buffer empty", irq, 1);
        wait_idle();
        chk(irq == 1'b1, "R9 irq held until cleared", irq, 1);
        pulse_irq_clr();
        chk(irq == 1'b0, "R9 irq cleared", irq, 0);

        // R9: request on transmission complete.
        irq_sel = 1'b1;
        push(9'h022, 0);
        wr(9'h022);
        @(negedge clk);
        chk(irq == 1'b0, "R9 no irq at load when completion selected", irq, 0);
        while (!shift_empty) @(negedge clk);
        chk(irq == 1'b1, "R9 irq on transmission complete", irq, 1);
        wait_idle();
        pulse_irq_clr();
        irq_sel = 1'b0;

        // R7: held by CTS, released when it falls.
        cts_en = 1'b1; cts_n = 1'b1;
        push(9'h044, 0);
        wr(9'h044);
        repeat (100) @(negedge clk);
        chk(shift_empty == 1'b1 && buf_empty == 1'b0 && txd == 1'b1,
            "R7 frame held while cts high", {shift_empty, buf_empty, txd}, 3'b101);
        cts_n = 1'b0;
        wait_idle();

        // R7: CTS rising mid-frame lets the frame finish and holds the next.
        push(9'h088, 0);
        push(9'h099, 0);
        f0 = rx_frames;
        wr(9'h088);
        @(negedge clk);
        wr(9'h099);
        cts_n = 1'b1;
        while (!shift_empty) @(negedge clk);
        repeat (bit_p()) @(negedge clk);
        chk(rx_frames == f0 + 1, "R7 frame in progress completed", rx_frames - f0, 1);
        chk(shift_empty == 1'b1 && buf_empty == 1'b0, "R7 next frame held",
            {shift_empty, buf_empty}, 2'b10);
        cts_n = 1'b0;
        wait_idle();
        cts_en = 1'b0;

        // R8: disabled transmitter keeps the word buffered.
        tx_en = 1'b0;
        push(9'h066, 0);
        wr(9'h066);
        repeat (100) @(negedge clk);
        chk(shift_empty == 1'b1 && buf_empty == 1'b0 && txd == 1'b1,
            "R8 no start while disabled", {shift_empty, buf_empty, txd}, 3'b101);
        tx_en = 1'b1;
        wait_idle();

        chk(q.size() == 0, "R5 all queued frames seen", q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule